// File: doc/BRIEF.md
# Edge Mask and Variance Detector

This block decides, for each lane of pixels across a block edge, whether the edge may be smoothed. A lane carries eight pixels: four on the near side (p3, p2, p1, p0, with p0 next to the edge) and four on the far side (q0, q1, q2, q3, with q0 next to the edge). Three shared 8-bit thresholds steer the decision. `limit_i` bounds the step between neighbouring pixels. `blimit_i` bounds the step across the edge itself. `thresh_i` separates edges with high variance from smooth ones.

For every lane the block returns three results. The first is a filter-enable flag. The second is a high-variance flag. The third is the larger of the two inner neighbour steps, which a later flatness stage reuses. All arithmetic is on unsigned absolute differences, with saturating adds. A single register stage, qualified by `valid_i`, holds the results.

Top module: `edge_mask_detect`

## Requirements
- R1: `side_max_o` for a lane equals max(|p1−p0|, |q1−q0|), where the differences are unsigned absolute values.
- R2: `hev_o` for a lane is 1 only when that lane's side maximum is strictly greater than `thresh_i`. Equality gives 0.
- R3: The edge strength is sat(sat(2·|p0−q0|) + (|p1−q1| >> 1)), where sat clips at 255. When the strength is strictly greater than `blimit_i`, a failure value of 255 joins the reduction of R4. Otherwise that term is 0.
- R4: `mask_o` for a lane is 1 exactly when the maximum of the following terms is ≤ `limit_i`: the side maximum, |p3−p2|, |p2−p1|, |q2−q1|, |q3−q2| and the failure term.
- R5: When `limit_i` is 255, `mask_o` is 1 whatever the pixels are, even when the strength exceeds `blimit_i`.
- R6: Lane l occupies bits [8l+7:8l] of every pixel port and of `side_max_o`, and bit l of `mask_o` and `hev_o`. Lanes are evaluated independently of one another. All lanes share the three thresholds.
- R7: A sample is taken on a rising edge where `valid_i` is 1. Its results appear after that edge, and `valid_o` is 1 for exactly the cycle that follows each such edge.
- R8: On edges where `valid_i` is 0, `mask_o`, `hev_o` and `side_max_o` keep their values, whatever the pixel and threshold inputs do.
- R9: While `rst_ni` is low, `valid_o`, `mask_o`, `hev_o` and `side_max_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample valid |
| p3_i | input | LANES*8 | Outermost near-side pixel per lane |
| p2_i | input | LANES*8 | Near-side pixel 2 per lane |
| p1_i | input | LANES*8 | Near-side pixel 1 per lane |
| p0_i | input | LANES*8 | Near-side pixel next to the edge |
| q0_i | input | LANES*8 | Far-side pixel next to the edge |
| q1_i | input | LANES*8 | Far-side pixel 1 per lane |
| q2_i | input | LANES*8 | Far-side pixel 2 per lane |
| q3_i | input | LANES*8 | Outermost far-side pixel per lane |
| limit_i | input | 8 | Neighbour step limit |
| blimit_i | input | 8 | Edge strength limit |
| thresh_i | input | 8 | Variance threshold |
| valid_o | output | 1 | Results valid |
| mask_o | output | LANES | Filter-enable flag per lane |
| hev_o | output | LANES | High-variance flag per lane |
| side_max_o | output | LANES*8 | Inner side maximum per lane |

## Verification
The clocked properties compare registered flags against the thresholds that were present one cycle earlier. They therefore assume that the thresholds are sampled on the same edge as the pixels and are free of X while `valid_i` is high. The stimulus changes inputs only on falling edges and holds `valid_i` at 0 throughout reset. It also keeps every pixel and threshold defined from time zero, so each `$past` value refers to a sample that was actually driven.

// File: rtl/edge_det_pkg.sv
package edge_det_pkg;
  localparam int PIX_W = 8;
  typedef logic [PIX_W-1:0] pix_t;

  function automatic pix_t abs_diff(input pix_t a, input pix_t b);
    return (a > b) ? pix_t'(a - b) : pix_t'(b - a);
  endfunction

  function automatic pix_t sat_add(input pix_t a, input pix_t b);
    logic [PIX_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[PIX_W] ? '1 : s[PIX_W-1:0];
  endfunction

  function automatic pix_t max2(input pix_t a, input pix_t b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/edge_strength_unit.sv
module edge_strength_unit
  import edge_det_pkg::*;
(
  input  pix_t p1_i,
  input  pix_t p0_i,
  input  pix_t q0_i,
  input  pix_t q1_i,
  input  pix_t blimit_i,
  output pix_t strength_o,
  output logic fail_o
);
  pix_t d_centre, d_outer, d_double;

  always_comb begin
    d_centre   = abs_diff(p0_i, q0_i);
    d_outer    = abs_diff(p1_i, q1_i);
    d_double   = sat_add(d_centre, d_centre);
    strength_o = sat_add(d_double, d_outer >> 1);
    fail_o     = strength_o > blimit_i;
  end
endmodule

// File: rtl/edge_lane_eval.sv
module edge_lane_eval
  import edge_det_pkg::*;
(
  input  pix_t p3_i,
  input  pix_t p2_i,
  input  pix_t p1_i,
  input  pix_t p0_i,
  input  pix_t q0_i,
  input  pix_t q1_i,
  input  pix_t q2_i,
  input  pix_t q3_i,
  input  pix_t limit_i,
  input  pix_t blimit_i,
  input  pix_t thresh_i,
  output logic mask_o,
  output logic hev_o,
  output pix_t side_max_o
);
  pix_t d_p32, d_p21, d_p10, d_q10, d_q21, d_q32;
  pix_t strength, fail_term, peak;
  logic fail;

  edge_strength_unit u_strength (
    .p1_i      (p1_i),
    .p0_i      (p0_i),
    .q0_i      (q0_i),
    .q1_i      (q1_i),
    .blimit_i  (blimit_i),
    .strength_o(strength),
    .fail_o    (fail)
  );

  always_comb begin
    d_p32 = abs_diff(p3_i, p2_i);
    d_p21 = abs_diff(p2_i, p1_i);
    d_p10 = abs_diff(p1_i, p0_i);
    d_q10 = abs_diff(q1_i, q0_i);
    d_q21 = abs_diff(q2_i, q1_i);
    d_q32 = abs_diff(q3_i, q2_i);
    side_max_o = max2(d_p10, d_q10);
    hev_o      = side_max_o > thresh_i;
    // strength failure injects full-scale into the reduction
    fail_term  = fail ? '1 : '0;
    peak = max2(max2(side_max_o, fail_term),
                max2(max2(d_p32, d_p21), max2(d_q21, d_q32)));
    mask_o = !(peak > limit_i);
  end

  logic unused_strength;
  assign unused_strength = ^strength;
endmodule

// File: rtl/edge_out_stage.sv
module edge_out_stage
  import edge_det_pkg::*;
#(
  parameter int LANES   = 4,
  parameter bit OUT_REG = 1'b1,
  localparam int SIDE_W = LANES * PIX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [LANES-1:0]  mask_i,
  input  logic [LANES-1:0]  hev_i,
  input  logic [SIDE_W-1:0] side_i,
  output logic              valid_o,
  output logic [LANES-1:0]  mask_o,
  output logic [LANES-1:0]  hev_o,
  output logic [SIDE_W-1:0] side_o
);
  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o <= 1'b0;
        mask_o  <= '0;
        hev_o   <= '0;
        side_o  <= '0;
      end else begin
        valid_o <= valid_i;
        if (valid_i) begin
          mask_o <= mask_i;
          hev_o  <= hev_i;
          side_o <= side_i;
        end
      end
    end
  end else begin : g_pass
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign valid_o = valid_i;
    assign mask_o  = mask_i;
    assign hev_o   = hev_i;
    assign side_o  = side_i;
  end
endmodule

// File: rtl/edge_mask_detect.sv
module edge_mask_detect
  import edge_det_pkg::*;
#(
  parameter int LANES   = 4,
  parameter bit OUT_REG = 1'b1,
  localparam int BUS_W  = LANES * PIX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [BUS_W-1:0] p3_i,
  input  logic [BUS_W-1:0] p2_i,
  input  logic [BUS_W-1:0] p1_i,
  input  logic [BUS_W-1:0] p0_i,
  input  logic [BUS_W-1:0] q0_i,
  input  logic [BUS_W-1:0] q1_i,
  input  logic [BUS_W-1:0] q2_i,
  input  logic [BUS_W-1:0] q3_i,
  input  logic [7:0]       limit_i,
  input  logic [7:0]       blimit_i,
  input  logic [7:0]       thresh_i,
  output logic             valid_o,
  output logic [LANES-1:0] mask_o,
  output logic [LANES-1:0] hev_o,
  output logic [BUS_W-1:0] side_max_o
);
  logic [LANES-1:0] lane_mask, lane_hev;
  logic [BUS_W-1:0] lane_side;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    edge_lane_eval u_lane (
      .p3_i      (p3_i[l*PIX_W +: PIX_W]),
      .p2_i      (p2_i[l*PIX_W +: PIX_W]),
      .p1_i      (p1_i[l*PIX_W +: PIX_W]),
      .p0_i      (p0_i[l*PIX_W +: PIX_W]),
      .q0_i      (q0_i[l*PIX_W +: PIX_W]),
      .q1_i      (q1_i[l*PIX_W +: PIX_W]),
      .q2_i      (q2_i[l*PIX_W +: PIX_W]),
      .q3_i      (q3_i[l*PIX_W +: PIX_W]),
      .limit_i   (limit_i),
      .blimit_i  (blimit_i),
      .thresh_i  (thresh_i),
      .mask_o    (lane_mask[l]),
      .hev_o     (lane_hev[l]),
      .side_max_o(lane_side[l*PIX_W +: PIX_W])
    );
  end

  edge_out_stage #(.LANES(LANES), .OUT_REG(OUT_REG)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .mask_i (lane_mask),
    .hev_i  (lane_hev),
    .side_i (lane_side),
    .valid_o(valid_o),
    .mask_o (mask_o),
    .hev_o  (hev_o),
    .side_o (side_max_o)
  );

  if (OUT_REG) begin : g_chk
    p_valid_lat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o == $past(valid_i));

    for (genvar l = 0; l < LANES; l++) begin : g_chk_lane
      p_hev_thresh_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> (hev_o[l] == (side_max_o[l*PIX_W +: PIX_W] > $past(thresh_i))));
      p_mask_limit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && mask_o[l]) |-> (side_max_o[l*PIX_W +: PIX_W] <= $past(limit_i)));
      p_lim_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && ($past(limit_i) == 8'hFF)) |-> mask_o[l]);
      p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(valid_i) |-> ($stable(mask_o[l]) && $stable(hev_o[l])
                             && $stable(side_max_o[l*PIX_W +: PIX_W])));
    end
  end
endmodule

// File: tb/edge_mask_detect_test.sv
module edge_mask_detect_test;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [7:0] pix [LANES][8];
  logic [7:0] lim = 8'd0, blim = 8'd0, thr = 8'd0;
  logic [LANES*W-1:0] p3_w, p2_w, p1_w, p0_w, q0_w, q1_w, q2_w, q3_w;
  logic valid_o;
  logic [LANES-1:0] mask_o, hev_o;
  logic [LANES*W-1:0] side_max_o;
  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] lfsr = 32'hACE1_1234;

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    for (int l = 0; l < LANES; l++)
      for (int k = 0; k < 8; k++) pix[l][k] = 8'd0;
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      p3_w[l*W +: W] = pix[l][0];
      p2_w[l*W +: W] = pix[l][1];
      p1_w[l*W +: W] = pix[l][2];
      p0_w[l*W +: W] = pix[l][3];
      q0_w[l*W +: W] = pix[l][4];
      q1_w[l*W +: W] = pix[l][5];
      q2_w[l*W +: W] = pix[l][6];
      q3_w[l*W +: W] = pix[l][7];
    end
  end

  edge_mask_detect #(.LANES(LANES)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i),
    .p3_i(p3_w), .p2_i(p2_w), .p1_i(p1_w), .p0_i(p0_w),
    .q0_i(q0_w), .q1_i(q1_w), .q2_i(q2_w), .q3_i(q3_w),
    .limit_i(lim), .blimit_i(blim), .thresh_i(thr),
    .valid_o(valid_o), .mask_o(mask_o), .hev_o(hev_o), .side_max_o(side_max_o)
  );

  function automatic int ad(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  // returns {mask, hev, side[7:0]}
  function automatic logic [9:0] model(input logic [7:0] v [8], input int li, input int bl, input int th);
    int side, str, peak;
    side = ad(v[2], v[3]) > ad(v[5], v[4]) ? ad(v[2], v[3]) : ad(v[5], v[4]);
    str = 2 * ad(v[3], v[4]) + ad(v[2], v[5]) / 2;
    if (str > 255) str = 255;
    peak = side;
    if (ad(v[0], v[1]) > peak) peak = ad(v[0], v[1]);
    if (ad(v[1], v[2]) > peak) peak = ad(v[1], v[2]);
    if (ad(v[6], v[5]) > peak) peak = ad(v[6], v[5]);
    if (ad(v[7], v[6]) > peak) peak = ad(v[7], v[6]);
    if (str > bl) peak = 255;
    return {peak <= li, side > th, 8'(side)};
  endfunction

  task automatic check_val(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_lane(input string req, input int l);
    logic [9:0] e;
    e = model(pix[l], lim, blim, thr);
    check_val({req, " mask"}, mask_o[l], e[9]);
    check_val({req, " hev"}, hev_o[l], e[8]);
    check_val({req, " side"}, side_max_o[l*W +: W], e[7:0]);
  endtask

  task automatic apply();
    @(negedge clk) valid_i = 1'b1;
    @(negedge clk) valid_i = 1'b0;
    check_val("R7 valid_o", valid_o, 1);
  endtask

  task automatic set_lane(input int l, input int a0, a1, a2, a3, a4, a5, a6, a7);
    pix[l][0] = 8'(a0); pix[l][1] = 8'(a1); pix[l][2] = 8'(a2); pix[l][3] = 8'(a3);
    pix[l][4] = 8'(a4); pix[l][5] = 8'(a5); pix[l][6] = 8'(a6); pix[l][7] = 8'(a7);
  endtask

  task automatic test_reset();
    check_val("R9 valid_o", valid_o, 0);
    check_val("R9 mask_o", mask_o, 0);
    check_val("R9 hev_o", hev_o, 0);
    check_val("R9 side_max_o", side_max_o, 0);
  endtask

  task automatic test_flat();
    for (int l = 0; l < LANES; l++) set_lane(l, 90, 90, 90, 90, 90, 90, 90, 90);
    lim = 0; blim = 0; thr = 0;
    apply();
    for (int l = 0; l < LANES; l++) begin
      check_val("R4 flat mask", mask_o[l], 1);
      check_val("R2 flat hev", hev_o[l], 0);
      check_val("R1 flat side", side_max_o[l*W +: W], 0);
    end
    @(negedge clk) check_val("R7 valid single cycle", valid_o, 0);
  endtask

  task automatic test_hev_edge();
    set_lane(0, 50, 50, 50, 57, 57, 57, 57, 57);   // |p1-p0| = 7
    set_lane(1, 50, 50, 50, 50, 60, 69, 69, 69);   // |q1-q0| = 9
    set_lane(2, 50, 50, 50, 57, 57, 57, 57, 57);
    set_lane(3, 20, 20, 20, 20, 20, 20, 20, 20);
    lim = 40; blim = 255; thr = 7;
    apply();
    check_val("R2 equal thresh", hev_o[0], 0);
    check_val("R2 above thresh", hev_o[1], 1);
    check_val("R1 q side", side_max_o[1*W +: W], 9);
    for (int l = 0; l < LANES; l++) check_lane("R2", l);
    thr = 6;
    apply();
    check_val("R2 thresh minus one", hev_o[0], 1);
  endtask

  task automatic test_limit_edge();
    set_lane(0, 0, 12, 12, 12, 12, 12, 12, 12);    // |p3-p2| = 12
    set_lane(1, 12, 12, 12, 12, 12, 12, 12, 24);   // |q3-q2| = 12
    set_lane(2, 12, 12, 24, 24, 24, 24, 24, 24);   // |p2-p1| = 12
    set_lane(3, 30, 30, 30, 30, 30, 30, 18, 18);   // |q2-q1| = 12
    lim = 12; blim = 255; thr = 255;
    apply();
    for (int l = 0; l < LANES; l++) check_val("R4 at limit", mask_o[l], 1);
    lim = 11;
    apply();
    for (int l = 0; l < LANES; l++) check_val("R4 over limit", mask_o[l], 0);
  endtask

  task automatic test_blimit_edge();
    // strength = 2*10 + 30/2 = 35
    for (int l = 0; l < LANES; l++) set_lane(l, 10, 10, 10, 20, 30, 40, 40, 40);
    lim = 20; thr = 255; blim = 35;
    apply();
    check_val("R3 strength at blimit", mask_o[0], 1);
    blim = 34;
    apply();
    check_val("R3 strength over blimit", mask_o[0], 0);
    for (int l = 0; l < LANES; l++) check_lane("R3", l);
  endtask

  task automatic test_saturation();
    // 2*200 clips to 255
    for (int l = 0; l < LANES; l++) set_lane(l, 0, 0, 0, 0, 200, 200, 200, 200);
    thr = 0; blim = 254; lim = 254;
    apply();
    check_val("R3 saturated fail", mask_o[0], 0);
    lim = 255;
    apply();
    check_val("R5 limit full scale", mask_o[0], 1);
    blim = 255; lim = 0;
    apply();
    check_val("R3 saturated never above 255", mask_o[0], 1);
  endtask

  task automatic test_lanes();
    set_lane(0, 100, 100, 100, 100, 100, 100, 100, 100);
    set_lane(1, 100, 100, 100, 130, 130, 100, 100, 100);
    set_lane(2, 5, 200, 5, 5, 5, 5, 5, 5);
    set_lane(3, 40, 41, 43, 46, 48, 51, 53, 54);
    lim = 10; blim = 20; thr = 2;
    apply();
    check_val("R6 lane0 mask", mask_o[0], 1);
    check_val("R6 lane1 mask", mask_o[1], 0);
    check_val("R6 lane1 side", side_max_o[1*W +: W], 30);
    check_val("R6 lane2 mask", mask_o[2], 0);
    check_val("R6 lane3 hev", hev_o[3], 1);
    for (int l = 0; l < LANES; l++) check_lane("R6", l);
  endtask

  task automatic test_hold();
    logic [LANES-1:0] m0, h0;
    logic [LANES*W-1:0] s0;
    for (int l = 0; l < LANES; l++) set_lane(l, 60, 60, 60, 60, 60, 60, 60, 60);
    lim = 5; blim = 5; thr = 0;
    apply();
    m0 = mask_o; h0 = hev_o; s0 = side_max_o;
    for (int l = 0; l < LANES; l++) set_lane(l, 0, 255, 0, 255, 0, 255, 0, 255);
    lim = 0; blim = 0; thr = 0;
    @(negedge clk);
    @(negedge clk);
    check_val("R8 hold mask", mask_o, m0);
    check_val("R8 hold hev", hev_o, h0);
    check_val("R8 hold side", side_max_o, s0);
    check_val("R8 valid low", valid_o, 0);
  endtask

  function automatic logic [31:0] step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic test_sweep();
    for (int n = 0; n < 300; n++) begin
      for (int l = 0; l < LANES; l++) begin
        lfsr = step(lfsr);
        for (int k = 0; k < 8; k++) begin
          lfsr = step(lfsr);
          pix[l][k] = (n % 3 == 0) ? lfsr[7:0] : 8'(int'(lfsr[15:8] & 8'h7F) + int'(lfsr[3:0]));
        end
      end
      lfsr = step(lfsr);
      lim = lfsr[7:0] & 8'h1F; blim = lfsr[15:8] & 8'h7F; thr = lfsr[23:16] & 8'h0F;
      if (n % 17 == 0) lim = 8'hFF;
      apply();
      for (int l = 0; l < LANES; l++) check_lane("R1 R2 R3 R4 sweep", l);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    test_flat();
    test_hev_edge();
    test_limit_edge();
    test_blimit_edge();
    test_saturation();
    test_lanes();
    test_hold();
    test_sweep();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule